// File: doc/BRIEF.md
# SPI Command Register File for a CAN Controller

This block sits between an SPI host and the register space of a small CAN controller. The host sends one instruction byte per chip-select frame. The block decodes it and then serves plain register reads and writes, masked bit updates, fast loads into transmit buffers, fast reads from receive buffers, transmit-request strobes and a soft reset. The interface is SPI mode 0 with 8-bit words, most significant bit first. SCK, MOSI and the active-low chip select are oversampled by the system clock.

The rest of the controller sees the register state in parallel. It gets the control byte, the status byte, the interrupt flags, the transmit-request bit of each transmit buffer, and a combinational peek port into any address. It can raise interrupt flags and retire transmit requests. The requested operating mode is written into the control register, and the status register reports the granted mode a fixed number of system clocks later. An active-low interrupt pin is asserted whenever an enabled flag is pending.

Top module: `spi_can_regs`

## Requirements
- R1: After reset the control register (0x0F) reads 0x87, the status register (0x0E) reads 0x80, and the interrupt flags and transmit requests are all zero. irq_n is high, and reads of 0x0E and 0x0F over SPI give 0x80 under mask 0xEE and 0x07 under mask 0x17.
- R2: Instruction 0x03 followed by an address returns that register's value from the third byte on. Each further byte returns the next address, and the address wraps from 0x7F to 0x00.
- R3: Instruction 0x02 followed by an address writes each following byte to consecutive addresses, wrapping from 0x7F to 0x00.
- R4: Instruction 0x05 takes an address, a mask byte and a data byte, and changes only the register bits whose mask bit is 1. Any bytes after the data byte have no effect.
- R5: Instruction 0x40, 0x42 or 0x44 (buffer n = 0, 1, 2) writes the following bytes starting at address 0x31 + 0x10·n.
- R6: Instruction 0x90 or 0x94 (receive buffer 0 or 1) returns bytes starting at address 0x61 + 0x10·n, beginning with the second byte of the frame.
- R7: Instruction 0x80 | m sets bit 3 of the buffer control register at 0x30 + 0x10·n for every set bit n of the 3-bit mask m. It leaves the other buffers alone, and m = 0 changes nothing.
- R8: Instruction 0xC0 returns every register to its reset value.
- R9: Control bits 7:5 request a mode (000 normal, 001 sleep, 010 loopback, 011 listen-only, 100 configuration). Status bits 7:5 show the requested code exactly 4 system clocks after the control register changes. Writes to the status register are ignored.
- R10: Interrupt enables sit at 0x2B and flags at 0x2C, with the same layout: bit 0 receive 0, bit 1 receive 1, bits 2 to 4 transmit 0 to 2, bit 5 error, bit 6 wake, bit 7 message error. A pulse on flag_set sets flags, an SPI write can clear them, and irq_n is low exactly when some flag and its enable are both 1.
- R11: An unrecognised instruction byte makes the rest of the frame have no effect, and the next frame is decoded normally.
- R12: A pulse on bit n of tx_clear clears bit 3 of transmit buffer n's control register.
- R13: Raising chip select in the middle of a byte drops the partial byte, and the next frame starts at a fresh instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock (idle low) |
| mosi | input | 1 | SPI data from host |
| cs_n | input | 1 | SPI chip select, active low |
| miso | output | 1 | SPI data to host, low when not selected |
| flag_set | input | 8 | One-cycle pulses that set interrupt flags |
| tx_clear | input | 3 | One-cycle pulses that retire transmit requests |
| view_addr | input | 7 | Peek address |
| view_data | output | 8 | Register value at view_addr |
| ctrl_o | output | 8 | Control register |
| stat_o | output | 8 | Status register |
| int_flags | output | 8 | Interrupt flag register |
| tx_req | output | 3 | Transmit-request bit of each transmit buffer |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that soft reset, transmit-request strobes and flag_set pulses arrive only as clean single-cycle pulses, and that flag_set and tx_clear never collide with the same bit of an SPI write in one cycle. They also assume the mode history is measured from the last reset of either kind. The bench drives SCK at ten system clocks per bit, so the synchronisers always see each level. It changes flag_set and tx_clear only between SPI frames, and it reads MISO halfway through the low phase of SCK, well after the outgoing byte has been loaded.

// File: rtl/canspi_pkg.sv
package canspi_pkg;
    localparam int AW   = 7;
    localparam int DW   = 8;
    localparam int NREG = 1 << AW;

    localparam logic [AW-1:0] ADDR_STAT = 7'h0E;
    localparam logic [AW-1:0] ADDR_CTRL = 7'h0F;
    localparam logic [AW-1:0] ADDR_IEN  = 7'h2B;
    localparam logic [AW-1:0] ADDR_IFL  = 7'h2C;

    localparam logic [DW-1:0] OP_WRITE  = 8'h02;
    localparam logic [DW-1:0] OP_READ   = 8'h03;
    localparam logic [DW-1:0] OP_BITMOD = 8'h05;
    localparam logic [DW-1:0] OP_RESET  = 8'hC0;

    localparam logic [2:0]    MODE_CONF = 3'b100;
    localparam logic [DW-1:0] CTRL_RST  = 8'h87;
    localparam int            TXREQ_BIT = 3;

    typedef enum logic [3:0] {
        S_OP, S_RADDR, S_RDATA, S_WADDR, S_WDATA,
        S_MADDR, S_MMASK, S_MDATA, S_SKIP
    } seq_st_e;

    // control register of transmit buffer i
    function automatic logic [AW-1:0] txctl_addr(input int i);
        return AW'(48 + 16 * i);
    endfunction

    // first identifier byte of transmit buffer n
    function automatic logic [AW-1:0] txbuf_first(input logic [1:0] n);
        return 7'h31 + AW'({n, 4'h0});
    endfunction

    // first identifier byte of receive buffer n
    function automatic logic [AW-1:0] rxbuf_first(input logic n);
        return 7'h61 + AW'({n, 4'h0});
    endfunction
endpackage

// File: rtl/canspi_byte_port.sv
module canspi_byte_port #(
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       mosi,
    input  logic       cs_n,
    input  logic [7:0] tx_byte,
    output logic       miso,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic       cs_end
);
    typedef struct packed {
        logic [SYNC-1:0] sck_sy;
        logic [SYNC-1:0] mosi_sy;
        logic [SYNC-1:0] cs_sy;
        logic            sck_last;
        logic            cs_last;
        logic [2:0]      cnt;
        logic [6:0]      sh;
        logic            done;
        logic [7:0]      rxb;
        logic            cs_end;
    } bp_s;

    bp_s q, d;
    logic sck_s, mosi_s, cs_s;

    assign sck_s  = q.sck_sy[SYNC-1];
    assign mosi_s = q.mosi_sy[SYNC-1];
    assign cs_s   = q.cs_sy[SYNC-1];

    always_comb begin
        d          = q;
        d.sck_sy   = {q.sck_sy[SYNC-2:0], sck};
        d.mosi_sy  = {q.mosi_sy[SYNC-2:0], mosi};
        d.cs_sy    = {q.cs_sy[SYNC-2:0], cs_n};
        d.sck_last = sck_s;
        d.cs_last  = cs_s;
        d.done     = 1'b0;
        d.cs_end   = cs_s & ~q.cs_last;
        if (cs_s) begin
            d.cnt = '0;
        end else if (sck_s && !q.sck_last) begin
            d.sh  = {q.sh[5:0], mosi_s};
            d.cnt = q.cnt + 3'd1;
            if (q.cnt == 3'd7) begin
                d.done = 1'b1;
                d.rxb  = {q.sh, mosi_s};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.cs_sy <= '1;
            q.cs_last <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // bit for the next rising edge is chosen by the count of bits taken
    assign miso      = cs_s ? 1'b0 : tx_byte[3'd7 - q.cnt];
    assign byte_done = q.done;
    assign rx_byte   = q.rxb;
    assign cs_end    = q.cs_end;
endmodule

// File: rtl/canspi_cmd_seq.sv
module canspi_cmd_seq
    import canspi_pkg::*;
#(
    parameter int NTX = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_done,
    input  logic [7:0]    rx_byte,
    input  logic          cs_end,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic [7:0]    wr_mask,
    output logic [NTX-1:0] rts,
    output logic          soft_rst,
    output logic [7:0]    tx_byte
);
    typedef struct packed {
        seq_st_e       st;
        logic [AW-1:0] addr;
        logic [7:0]    mask;
        logic [7:0]    tx;
    } seq_s;

    seq_s q, d;

    always_comb begin
        d        = q;
        rd_addr  = q.addr;
        wr_en    = 1'b0;
        wr_addr  = q.addr;
        wr_data  = rx_byte;
        wr_mask  = 8'hFF;
        rts      = '0;
        soft_rst = 1'b0;
        if (byte_done) begin
            d.tx = 8'h00;
            case (q.st)
                S_OP: begin
                    if (rx_byte == OP_READ) begin
                        d.st = S_RADDR;
                    end else if (rx_byte == OP_WRITE) begin
                        d.st = S_WADDR;
                    end else if (rx_byte == OP_BITMOD) begin
                        d.st = S_MADDR;
                    end else if (rx_byte == OP_RESET) begin
                        soft_rst = 1'b1;
                        d.st     = S_SKIP;
                    end else if (rx_byte[7:3] == 5'b01000 && !rx_byte[0]
                                 && int'(rx_byte[2:1]) < NTX) begin
                        d.addr = txbuf_first(rx_byte[2:1]);
                        d.st   = S_WDATA;
                    end else if (rx_byte[7:3] == 5'b10010 && rx_byte[1:0] == 2'b00) begin
                        rd_addr = rxbuf_first(rx_byte[2]);
                        d.tx    = rd_data;
                        d.addr  = rd_addr + 7'd1;
                        d.st    = S_RDATA;
                    end else if (rx_byte[7:3] == 5'b10000) begin
                        rts  = rx_byte[NTX-1:0];
                        d.st = S_SKIP;
                    end else begin
                        d.st = S_SKIP;
                    end
                end
                S_RADDR: begin
                    rd_addr = rx_byte[AW-1:0];
                    d.tx    = rd_data;
                    d.addr  = rd_addr + 7'd1;
                    d.st    = S_RDATA;
                end
                S_RDATA: begin
                    d.tx   = rd_data;
                    d.addr = q.addr + 7'd1;
                end
                S_WADDR: begin
                    d.addr = rx_byte[AW-1:0];
                    d.st   = S_WDATA;
                end
                S_WDATA: begin
                    wr_en  = 1'b1;
                    d.addr = q.addr + 7'd1;
                end
                S_MADDR: begin
                    d.addr = rx_byte[AW-1:0];
                    d.st   = S_MMASK;
                end
                S_MMASK: begin
                    d.mask = rx_byte;
                    d.st   = S_MDATA;
                end
                S_MDATA: begin
                    wr_en   = 1'b1;
                    wr_mask = q.mask;
                    d.st    = S_SKIP;
                end
                default: d.st = S_SKIP;
            endcase
        end
        if (cs_end) begin
            d.st = S_OP;
            d.tx = 8'h00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_OP;
        end else begin
            q <= d;
        end
    end

    assign tx_byte = q.tx;
endmodule

// File: rtl/canspi_regbank.sv
module canspi_regbank
    import canspi_pkg::*;
#(
    parameter int NTX      = 3,
    parameter int MODE_LAT = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [7:0]     wr_data,
    input  logic [7:0]     wr_mask,
    input  logic [NTX-1:0] rts,
    input  logic           soft_rst,
    input  logic [7:0]     flag_set,
    input  logic [NTX-1:0] tx_clear,
    input  logic [AW-1:0]  rd_addr,
    output logic [7:0]     rd_data,
    input  logic [AW-1:0]  view_addr,
    output logic [7:0]     view_data,
    output logic [7:0]     ctrl_o,
    output logic [7:0]     stat_o,
    output logic [7:0]     int_flags,
    output logic [7:0]     int_en,
    output logic [NTX-1:0] tx_req
);
    typedef struct packed {
        logic [NREG-1:0][7:0]     mem;
        logic [MODE_LAT-1:0][2:0] pipe;
    } bank_s;

    bank_s q, d;

    function automatic bank_s bank_default();
        bank_s b;
        b.mem            = '0;
        b.mem[ADDR_CTRL] = CTRL_RST;
        for (int i = 0; i < MODE_LAT; i++) b.pipe[i] = MODE_CONF;
        return b;
    endfunction

    always_comb begin
        d = q;
        if (soft_rst) begin
            d = bank_default();
        end else begin
            if (wr_en && wr_addr != ADDR_STAT)
                d.mem[wr_addr] = (q.mem[wr_addr] & ~wr_mask) | (wr_data & wr_mask);
            for (int i = 0; i < NTX; i++) begin
                if (tx_clear[i]) d.mem[txctl_addr(i)][TXREQ_BIT] = 1'b0;
                if (rts[i])      d.mem[txctl_addr(i)][TXREQ_BIT] = 1'b1;
            end
            d.mem[ADDR_IFL] = d.mem[ADDR_IFL] | flag_set;
            d.pipe[0] = q.mem[ADDR_CTRL][7:5];
            for (int i = 1; i < MODE_LAT; i++) d.pipe[i] = q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= bank_default();
        else        q <= d;
    end

    assign stat_o    = {q.pipe[MODE_LAT-1], 5'b0};
    assign rd_data   = (rd_addr == ADDR_STAT) ? stat_o : q.mem[rd_addr];
    assign view_data = (view_addr == ADDR_STAT) ? stat_o : q.mem[view_addr];
    assign ctrl_o    = q.mem[ADDR_CTRL];
    assign int_flags = q.mem[ADDR_IFL];
    assign int_en    = q.mem[ADDR_IEN];

    for (genvar g = 0; g < NTX; g++) begin : g_txreq
        assign tx_req[g] = q.mem[txctl_addr(g)][TXREQ_BIT];
    end
endmodule

// File: rtl/spi_can_regs.sv
module spi_can_regs
    import canspi_pkg::*;
#(
    parameter int NTX      = 3,
    parameter int MODE_LAT = 4,
    parameter int SYNC     = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sck,
    input  logic           mosi,
    input  logic           cs_n,
    output logic           miso,
    input  logic [7:0]     flag_set,
    input  logic [NTX-1:0] tx_clear,
    input  logic [AW-1:0]  view_addr,
    output logic [7:0]     view_data,
    output logic [7:0]     ctrl_o,
    output logic [7:0]     stat_o,
    output logic [7:0]     int_flags,
    output logic [NTX-1:0] tx_req,
    output logic           irq_n
);
    logic           byte_done, cs_end, wr_en, srst_w;
    logic [7:0]     rx_byte, tx_byte, rd_data, wr_data, wr_mask, int_en;
    logic [AW-1:0]  rd_addr, wr_addr;
    logic [NTX-1:0] rts_w;

    canspi_byte_port #(.SYNC(SYNC)) u_port (
        .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .cs_n(cs_n),
        .tx_byte(tx_byte), .miso(miso), .byte_done(byte_done),
        .rx_byte(rx_byte), .cs_end(cs_end)
    );

    canspi_cmd_seq #(.NTX(NTX)) u_seq (
        .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .rx_byte(rx_byte),
        .cs_end(cs_end), .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
        .rts(rts_w), .soft_rst(srst_w), .tx_byte(tx_byte)
    );

    canspi_regbank #(.NTX(NTX), .MODE_LAT(MODE_LAT)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_mask(wr_mask), .rts(rts_w), .soft_rst(srst_w),
        .flag_set(flag_set), .tx_clear(tx_clear), .rd_addr(rd_addr),
        .rd_data(rd_data), .view_addr(view_addr), .view_data(view_data),
        .ctrl_o(ctrl_o), .stat_o(stat_o), .int_flags(int_flags),
        .int_en(int_en), .tx_req(tx_req)
    );

    assign irq_n = ~|(int_flags & int_en);
endmodule

// File: rtl/spi_can_regs_chk.sv
module spi_can_regs_chk #(
    parameter int NTX      = 3,
    parameter int MODE_LAT = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [7:0]     ctrl_o,
    input logic [7:0]     stat_o,
    input logic [7:0]     int_flags,
    input logic           irq_n,
    input logic [NTX-1:0] tx_req,
    input logic [7:0]     flag_set,
    input logic [NTX-1:0] tx_clear,
    input logic [NTX-1:0] rts,
    input logic           soft_rst
);
    // cycles since the last hardware or soft reset, saturating
    logic [2:0] since;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since <= '0;
        else if (soft_rst)         since <= '0;
        else if (since != 3'd7)    since <= since + 3'd1;
    end

    // R7: a transmit-request strobe leaves the selected bits set
    p_rts_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|rts) |=> ((tx_req & $past(rts)) == $past(rts)));

    // R12: a retire pulse without a competing strobe clears the bit
    p_txclr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (|(tx_clear & ~rts)) |=> ((tx_req & $past(tx_clear & ~rts)) == '0));

    // R8: soft reset restores the defaults
    p_srst_defaults_r8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ctrl_o == 8'h87 && stat_o == 8'h80 &&
                      int_flags == 8'h00 && tx_req == '0));

    // R10: raised flags are visible next cycle
    p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_set && !soft_rst) |=> ((int_flags & $past(flag_set)) == $past(flag_set)));

    // R10: no pending flag, no interrupt
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (int_flags == 8'h00) |-> irq_n);

    // R9: granted mode trails the requested one by four clocks
    if (MODE_LAT == 4) begin : g_lag
        p_mode_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (since >= 3'd4 && !soft_rst) |-> (stat_o[7:5] == $past(ctrl_o[7:5], 4)));
    end
endmodule

bind spi_can_regs spi_can_regs_chk #(.NTX(NTX), .MODE_LAT(MODE_LAT)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_o(ctrl_o), .stat_o(stat_o),
    .int_flags(int_flags), .irq_n(irq_n), .tx_req(tx_req),
    .flag_set(flag_set), .tx_clear(tx_clear), .rts(rts_w), .soft_rst(srst_w)
);

// File: tb/spi_can_regs_bench.sv
module spi_can_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
    logic       miso, irq_n;
    logic [7:0] flag_set = 8'h00;
    logic [2:0] tx_clear = 3'b000;
    logic [6:0] view_addr = 7'h00;
    logic [7:0] view_data, ctrl_o, stat_o, int_flags;
    logic [2:0] tx_req;

    int checks = 0;
    int errors = 0;
    logic [7:0] tb_tx [16];
    logic [7:0] tb_rx [16];

    always #5 clk = ~clk;

    spi_can_regs u_spi_can_regs (
        .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .cs_n(cs_n),
        .miso(miso), .flag_set(flag_set), .tx_clear(tx_clear),
        .view_addr(view_addr), .view_data(view_data), .ctrl_o(ctrl_o),
        .stat_o(stat_o), .int_flags(int_flags), .tx_req(tx_req), .irq_n(irq_n)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic spi_byte(input logic [7:0] b, input int nbits, output logic [7:0] r);
        r = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = b[i];
            #50;
            r[i] = miso;
            sck = 1'b1;
            #50;
            sck = 1'b0;
        end
    endtask

    // full frame of n bytes from tb_tx, replies in tb_rx
    task automatic xfer(input int n);
        logic [7:0] r;
        @(negedge clk);
        cs_n = 1'b0;
        #50;
        for (int k = 0; k < n; k++) begin
            spi_byte(tb_tx[k], 8, r);
            tb_rx[k] = r;
        end
        #50;
        cs_n = 1'b1;
        #200;
    endtask

    task automatic peek(input logic [6:0] a, output logic [7:0] v);
        @(negedge clk);
        view_addr = a;
        #1;
        v = view_data;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check8("R1 ctrl", ctrl_o, 8'h87);
        check8("R1 stat", stat_o, 8'h80);
        check8("R1 flags", int_flags, 8'h00);
        check8("R1 irq_n", {7'b0, irq_n}, 8'h01);
        check8("R1 tx_req", {5'b0, tx_req}, 8'h00);
        check8("R1 miso idle", {7'b0, miso}, 8'h00);
        tb_tx[0] = 8'h03; tb_tx[1] = 8'h0E; tb_tx[2] = 8'h00; tb_tx[3] = 8'h00;
        xfer(4);
        v = tb_rx[2] & 8'hEE;
        check8("R1 spi stat", v, 8'h80);
        v = tb_rx[3] & 8'h17;
        check8("R1 spi ctrl", v, 8'h07);
    endtask

    task automatic t_rw;
        logic [7:0] v;
        tb_tx[0] = 8'h02; tb_tx[1] = 8'h20; tb_tx[2] = 8'hA5; tb_tx[3] = 8'h5A;
        xfer(4);
        peek(7'h20, v); check8("R3 write 0x20", v, 8'hA5);
        peek(7'h21, v); check8("R3 write 0x21", v, 8'h5A);
        tb_tx[0] = 8'h03; tb_tx[1] = 8'h20; tb_tx[2] = 8'h00; tb_tx[3] = 8'h00;
        xfer(4);
        check8("R2 read first", tb_rx[2], 8'hA5);
        check8("R2 read next", tb_rx[3], 8'h5A);
        tb_tx[0] = 8'h02; tb_tx[1] = 8'h7F; tb_tx[2] = 8'h11; tb_tx[3] = 8'h22;
        xfer(4);
        peek(7'h7F, v); check8("R3 write 0x7F", v, 8'h11);
        peek(7'h00, v); check8("R3 wrap to 0x00", v, 8'h22);
        tb_tx[0] = 8'h03; tb_tx[1] = 8'h7F;
        xfer(4);
        check8("R2 read 0x7F", tb_rx[2], 8'h11);
        check8("R2 read wraps", tb_rx[3], 8'h22);
    endtask

    task automatic t_bitmod;
        logic [7:0] v;
        tb_tx[0] = 8'h02; tb_tx[1] = 8'h22; tb_tx[2] = 8'hF0;
        xfer(3);
        tb_tx[0] = 8'h05; tb_tx[1] = 8'h22; tb_tx[2] = 8'h3C; tb_tx[3] = 8'hAA; tb_tx[4] = 8'hFF;
        xfer(5);
        peek(7'h22, v); check8("R4 masked update", v, 8'hE8);
        peek(7'h23, v); check8("R4 trailing byte ignored", v, 8'h00);
    endtask

    task automatic t_load;
        logic [7:0] v;
        tb_tx[0] = 8'h42; tb_tx[1] = 8'h11; tb_tx[2] = 8'h22; tb_tx[3] = 8'h33;
        xfer(4);
        peek(7'h41, v); check8("R5 buf1 first", v, 8'h11);
        peek(7'h43, v); check8("R5 buf1 third", v, 8'h33);
        tb_tx[0] = 8'h44; tb_tx[1] = 8'h77;
        xfer(2);
        peek(7'h51, v); check8("R5 buf2 first", v, 8'h77);
        tb_tx[0] = 8'h40; tb_tx[1] = 8'h66;
        xfer(2);
        peek(7'h31, v); check8("R5 buf0 first", v, 8'h66);
    endtask

    task automatic t_rxread;
        tb_tx[0] = 8'h02; tb_tx[1] = 8'h61; tb_tx[2] = 8'hA1; tb_tx[3] = 8'hA2;
        xfer(4);
        tb_tx[0] = 8'h02; tb_tx[1] = 8'h71; tb_tx[2] = 8'hB1;
        xfer(3);
        tb_tx[0] = 8'h90; tb_tx[1] = 8'h00; tb_tx[2] = 8'h00;
        xfer(3);
        check8("R6 rx0 first", tb_rx[1], 8'hA1);
        check8("R6 rx0 second", tb_rx[2], 8'hA2);
        tb_tx[0] = 8'h94; tb_tx[1] = 8'h00;
        xfer(2);
        check8("R6 rx1 first", tb_rx[1], 8'hB1);
    endtask

    task automatic t_rts;
        logic [7:0] v;
        tb_tx[0] = 8'h80;
        xfer(1);
        check8("R7 empty mask", {5'b0, tx_req}, 8'h00);
        tb_tx[0] = 8'h85;
        xfer(1);
        check8("R7 mask 101", {5'b0, tx_req}, 8'h05);
        peek(7'h50, v); check8("R7 buf2 ctrl bit3", v, 8'h08);
        peek(7'h40, v); check8("R7 buf1 untouched", v, 8'h00);
        @(negedge clk); tx_clear = 3'b001;
        @(negedge clk); tx_clear = 3'b000;
        check8("R12 retire buf0", {5'b0, tx_req}, 8'h04);
    endtask

    task automatic t_mode;
        tb_tx[0] = 8'h02; tb_tx[1] = 8'h0F; tb_tx[2] = 8'h40;
        fork
            xfer(3);
            begin
                do @(negedge clk); while (ctrl_o[7:5] != 3'b010);
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    check8("R9 status still old", {5'b0, stat_o[7:5]}, 8'h04);
                end
                @(negedge clk);
                check8("R9 status after 4 clocks", {5'b0, stat_o[7:5]}, 8'h02);
            end
        join
        tb_tx[0] = 8'h02; tb_tx[1] = 8'h0E; tb_tx[2] = 8'hFF;
        xfer(3);
        tb_tx[0] = 8'h03; tb_tx[1] = 8'h0E; tb_tx[2] = 8'h00;
        xfer(3);
        check8("R9 status write ignored", tb_rx[2], 8'h40);
    endtask

    task automatic t_irq;
        tb_tx[0] = 8'h02; tb_tx[1] = 8'h2B; tb_tx[2] = 8'h05;
        xfer(3);
        @(negedge clk); flag_set = 8'h02;
        @(negedge clk); flag_set = 8'h00;
        check8("R10 flag raised", int_flags, 8'h02);
        check8("R10 disabled flag no irq", {7'b0, irq_n}, 8'h01);
        @(negedge clk); flag_set = 8'h04;
        @(negedge clk); flag_set = 8'h00;
        check8("R10 enabled flag irq", {7'b0, irq_n}, 8'h00);
        tb_tx[0] = 8'h02; tb_tx[1] = 8'h2C; tb_tx[2] = 8'h00;
        xfer(3);
        check8("R10 flags cleared", int_flags, 8'h00);
        check8("R10 irq released", {7'b0, irq_n}, 8'h01);
    endtask

    task automatic t_unknown;
        logic [7:0] v;
        tb_tx[0] = 8'h55; tb_tx[1] = 8'h02; tb_tx[2] = 8'h24; tb_tx[3] = 8'hEE;
        xfer(4);
        peek(7'h24, v); check8("R11 unknown opcode ignored", v, 8'h00);
        tb_tx[0] = 8'h02; tb_tx[1] = 8'h24; tb_tx[2] = 8'h9C;
        xfer(3);
        peek(7'h24, v); check8("R11 next frame decoded", v, 8'h9C);
    endtask

    task automatic t_abort;
        logic [7:0] v, r;
        @(negedge clk);
        cs_n = 1'b0;
        #50;
        spi_byte(8'h02, 8, r);
        spi_byte(8'h25, 8, r);
        spi_byte(8'hFF, 4, r);
        #50;
        cs_n = 1'b1;
        #200;
        peek(7'h25, v); check8("R13 partial byte dropped", v, 8'h00);
        tb_tx[0] = 8'h02; tb_tx[1] = 8'h25; tb_tx[2] = 8'h3C;
        xfer(3);
        peek(7'h25, v); check8("R13 fresh frame after abort", v, 8'h3C);
    endtask

    task automatic t_softreset;
        logic [7:0] v;
        tb_tx[0] = 8'hC0;
        xfer(1);
        check8("R8 ctrl default", ctrl_o, 8'h87);
        check8("R8 stat default", stat_o, 8'h80);
        check8("R8 tx_req cleared", {5'b0, tx_req}, 8'h00);
        peek(7'h20, v); check8("R8 memory cleared", v, 8'h00);
        peek(7'h2B, v); check8("R8 enables cleared", v, 8'h00);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_rw();
        t_bitmod();
        t_load();
        t_rxread();
        t_rts();
        t_mode();
        t_irq();
        t_unknown();
        t_abort();
        t_softreset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule